// File: doc/BRIEF.md
# Sync-Driven Standby Controller

This block decides, once per clock, whether a video digitizer front end runs or sits in standby, and derives from that decision the power enables of the switchable domains, the keep-alive indications of the always-on domains, the output enables of the data bus and of the sync-on-green output, and a flag that marks converted data as trustworthy. The decision comes either from sync activity (automatic mode) or from a software bit ORed with an external pin whose active level is programmable (manual mode).

After every return to the running state the conversion pipeline holds stale samples, so the block counts data-strobe pulses and keeps the valid flag low for the first six data sets; the seventh set is the first one flagged valid. Any entry into standby clears that count.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: With control bit 4 set (automatic mode), the pin and software bit 3 have no effect on `standby`.
- R2: In automatic mode `standby` is 0 one clock after any of sync status bits 2, 3, 6 or 7 is 1, and 1 one clock after all four are 0; the other status bits are ignored.
- R3: In manual mode (bit 4 clear) `standby` is the OR of software bit 3 and the active pin level; a pin change reaches `standby` on the third rising edge after it (two synchronizer stages plus the mode register).
- R4: Control bit 2 sets pin polarity: 1 means a high pin requests standby, 0 means a low pin requests standby.
- R5: `keep_alive` (serial interface, sync detector, sync-on-green path, bandgap) is all ones in every mode and during reset.
- R6: `en_gated` is all ones while running and all zeros in standby, unless R7 applies.
- R7: With control bit 1 set, standby keeps `en_gated` all ones while `data_oe` is still 0; `data_oe` equals the inverse of `standby`.
- R8: `sog_oe` is 0 whenever control bit 0 is 1 and 1 otherwise, in every mode.
- R9: `data_valid` stays 0 until six data-strobe pulses have been taken while running; it rises right after the sixth, so the seventh set is valid.
- R10: Strobes during standby are not counted, and any entry into standby clears the count and drops `data_valid` in the same cycle as `standby` rises.
- R11: After reset `standby` is 1 and `data_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_reg | input | 8 | Power control byte (bits 0..4 used) |
| pd_pin | input | 1 | Asynchronous standby request pin |
| sync_stat | input | 8 | Sync activity status byte (bits 2,3,6,7 used) |
| data_strobe | input | 1 | One-cycle pulse per converted data set |
| en_gated | output | 3 | Power enables of the switchable domains |
| keep_alive | output | 4 | Always-on domain indications |
| data_oe | output | 1 | Data bus output enable |
| sog_oe | output | 1 | Sync-on-green output enable |
| data_valid | output | 1 | Pipeline refilled, data trustworthy |
| standby | output | 1 | Current state: 0 running, 1 standby |

## Verification
The flush counter and the mode register can both act on the same clock edge: the sixth strobe of a refill may arrive in the very cycle that the software bit requests standby. The bench provokes this by raising bit 3 together with that strobe and then requires `data_valid` to remain 0, the count to be lost, and six fresh strobes to be needed after the block wakes again. A second collision, strobes arriving while standby is held, is judged the same way through `data_valid` after wake-up.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    localparam int CTRL_W      = 8;
    localparam int SOG_HIZ_BIT = 0;
    localparam int OUT_HIZ_BIT = 1;
    localparam int PIN_POL_BIT = 2;
    localparam int SW_PD_BIT   = 3;
    localparam int AUTO_BIT    = 4;
    localparam int KEEP_N      = 4;

    typedef struct packed {
        logic auto_en;
        logic sw_pd;
        logic pin_high;
        logic out_hiz;
        logic sog_hiz;
    } pwr_cfg_t;

    typedef enum logic {ST_RUN = 1'b0, ST_DOWN = 1'b1} pwr_state_t;

    function automatic pwr_cfg_t decode_cfg(input logic [CTRL_W-1:0] r);
        pwr_cfg_t c;
        c.auto_en  = r[AUTO_BIT];
        c.sw_pd    = r[SW_PD_BIT];
        c.pin_high = r[PIN_POL_BIT];
        c.out_hiz  = r[OUT_HIZ_BIT];
        c.sog_hiz  = r[SOG_HIZ_BIT];
        return c;
    endfunction

    function automatic logic sync_seen(input logic [CTRL_W-1:0] s);
        return s[7] | s[6] | s[3] | s[2];
    endfunction
endpackage

// File: rtl/pwr_pin_sync.sv
module pwr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pwr_cfg_t   cfg,
    input  logic       pin_sync,
    input  logic       activity,
    output pwr_state_t state
);
    logic pin_req;
    logic down_req;

    always_comb begin
        pin_req  = cfg.pin_high ? pin_sync : ~pin_sync;
        if (cfg.auto_en) down_req = ~activity;
        else             down_req = pin_req | cfg.sw_pd;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_DOWN;
        else     state <= down_req ? ST_DOWN : ST_RUN;
    end
endmodule

// File: rtl/pwr_flush_cnt.sv
module pwr_flush_cnt #(
    parameter int FLUSH_SETS = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic running,
    input  logic strobe,
    output logic filled
);
    localparam int CW = $clog2(FLUSH_SETS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FLUSH_SETS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !running)              cnt <= '0;
        else if (strobe && cnt != LIMIT)  cnt <= cnt + 1'b1;
    end

    assign filled = (cnt == LIMIT);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_pkg::*;
#(
    parameter int GATED_N    = 3,
    parameter int FLUSH_SETS = 6,
    parameter int SYNC_STG   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CTRL_W-1:0]    ctrl_reg,
    input  logic                 pd_pin,
    input  logic [CTRL_W-1:0]    sync_stat,
    input  logic                 data_strobe,
    output logic [GATED_N-1:0]   en_gated,
    output logic [KEEP_N-1:0]    keep_alive,
    output logic                 data_oe,
    output logic                 sog_oe,
    output logic                 data_valid,
    output logic                 standby
);
    pwr_cfg_t   cfg;
    pwr_state_t state;
    logic       pin_s;
    logic       running;
    logic       filled;

    assign cfg = decode_cfg(ctrl_reg);

    pwr_pin_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (pd_pin),
        .dout(pin_s)
    );

    pwr_mode_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .pin_sync(pin_s),
        .activity(sync_seen(sync_stat)),
        .state   (state)
    );

    assign running = (state == ST_RUN);

    pwr_flush_cnt #(.FLUSH_SETS(FLUSH_SETS)) u_flush (
        .clk    (clk),
        .rst    (rst),
        .running(running),
        .strobe (data_strobe),
        .filled (filled)
    );

    genvar g;
    generate
        for (g = 0; g < GATED_N; g++) begin : g_gate
            assign en_gated[g] = running | cfg.out_hiz;
        end
    endgenerate

    assign keep_alive = {KEEP_N{1'b1}};
    assign data_oe    = running;
    assign sog_oe     = ~cfg.sog_hiz;
    assign data_valid = running & filled;
    assign standby    = ~running;
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
    parameter int GATED_N = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [7:0]         ctrl_reg,
    input logic [7:0]         sync_stat,
    input logic [GATED_N-1:0] en_gated,
    input logic [3:0]         keep_alive,
    input logic               data_oe,
    input logic               data_valid,
    input logic               standby
);
    logic act;
    assign act = sync_stat[2] | sync_stat[3] | sync_stat[6] | sync_stat[7];

    p_auto_wake_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_reg[4] && act) |=> !standby);

    p_auto_sleep_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_reg[4] && !act) |=> standby);

    p_keep_alive_r5: assert property (@(posedge clk)
        keep_alive == 4'hF);

    p_gate_off_r6: assert property (@(posedge clk) disable iff (rst)
        (standby && !ctrl_reg[1]) |-> (en_gated == '0));

    p_bus_off_r7: assert property (@(posedge clk) disable iff (rst)
        standby |-> !data_oe);

    p_valid_run_r9: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> !standby);

    p_valid_drop_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(standby) |-> !data_valid);
endmodule

bind pwr_mode_ctrl pwr_mode_chk #(.GATED_N(GATED_N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_reg  (ctrl_reg),
    .sync_stat (sync_stat),
    .en_gated  (en_gated),
    .keep_alive(keep_alive),
    .data_oe   (data_oe),
    .data_valid(data_valid),
    .standby   (standby)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ctrl_reg = 8'h00;
    logic       pd_pin = 1'b0;
    logic [7:0] sync_stat = 8'h00;
    logic       data_strobe = 1'b0;
    logic [2:0] en_gated;
    logic [3:0] keep_alive;
    logic       data_oe, sog_oe, data_valid, standby;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwr_mode_ctrl u0 (
        .clk(clk), .rst(rst), .ctrl_reg(ctrl_reg), .pd_pin(pd_pin),
        .sync_stat(sync_stat), .data_strobe(data_strobe),
        .en_gated(en_gated), .keep_alive(keep_alive), .data_oe(data_oe),
        .sog_oe(sog_oe), .data_valid(data_valid), .standby(standby)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h ctrl=%0h sync=%0h pin=%0b",
                     req, act, exp, ctrl_reg, sync_stat, pd_pin);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        data_strobe = 1'b1;
        step(1);
        data_strobe = 1'b0;
    endtask

    function automatic logic exp_sb(input logic [7:0] c, input logic [7:0] s, input logic p);
        if (c[4]) return !(s[2] | s[3] | s[6] | s[7]);
        return (c[2] ? p : !p) | c[3];
    endfunction

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        // R11 / R5 reset state
        chk("R11 standby", {7'd0, standby}, 8'd1);
        chk("R11 valid", {7'd0, data_valid}, 8'd0);
        chk("R5 keep_alive in reset", {4'd0, keep_alive}, 8'h0F);
        rst = 1'b0;
        step(1);

        // R1..R8 sweep: control bits 0..4, every sync byte, both pin levels
        for (int c = 0; c < 32; c++) begin
            for (int s = 0; s < 256; s += ((c[4]) ? 1 : 17)) begin
                for (int p = 0; p < 2; p++) begin
                    logic e;
                    ctrl_reg  = 8'(c);
                    sync_stat = 8'(s);
                    pd_pin    = p[0];
                    step(4);
                    e = exp_sb(8'(c), 8'(s), p[0]);
                    chk(c[4] ? "R1/R2 standby auto" : "R3/R4 standby manual",
                        {7'd0, standby}, {7'd0, e});
                    chk((e && c[1]) ? "R7 gated held" : "R6 gated",
                        {5'd0, en_gated}, (!e || c[1]) ? 8'h07 : 8'h00);
                    chk("R7 data_oe", {7'd0, data_oe}, {7'd0, !e});
                    chk("R8 sog_oe", {7'd0, sog_oe}, {7'd0, !c[0]});
                    chk("R5 keep_alive", {4'd0, keep_alive}, 8'h0F);
                end
            end
        end

        // R2 one-clock latency in automatic mode
        ctrl_reg = 8'h10; sync_stat = 8'h00; step(2);
        sync_stat = 8'h40; step(1);
        chk("R2 wake after one clock", {7'd0, standby}, 8'd0);
        sync_stat = 8'h33; step(1);
        chk("R2 other bits ignored", {7'd0, standby}, 8'd1);

        // R3 pin latency: third edge
        ctrl_reg = 8'h04; pd_pin = 1'b0; step(4);
        pd_pin = 1'b1; step(2);
        chk("R3 pin not yet through", {7'd0, standby}, 8'd0);
        step(1);
        chk("R3 pin on third edge", {7'd0, standby}, 8'd1);

        // R9 refill: six strobes, valid from the sixth onward
        pd_pin = 1'b0; step(4);
        for (int i = 1; i <= 7; i++) begin
            pulse();
            chk("R9 valid after strobe", {7'd0, data_valid}, {7'd0, i >= 6});
        end

        // R10 strobes during standby not counted, count cleared
        pd_pin = 1'b1; step(3);
        chk("R10 valid dropped", {7'd0, data_valid}, 8'd0);
        for (int i = 0; i < 10; i++) pulse();
        pd_pin = 1'b0; step(4);
        for (int i = 1; i <= 6; i++) begin
            pulse();
            chk("R10 recount after standby", {7'd0, data_valid}, {7'd0, i == 6});
        end

        // R10 collision: sixth strobe in the same cycle as standby request
        ctrl_reg = 8'h0C; step(2);
        ctrl_reg = 8'h04; step(2);
        for (int i = 1; i <= 5; i++) pulse();
        chk("R9 five strobes not enough", {7'd0, data_valid}, 8'd0);
        ctrl_reg = 8'h0C; data_strobe = 1'b1; step(1); data_strobe = 1'b0;
        chk("R10 collision standby", {7'd0, standby}, 8'd1);
        chk("R10 collision valid", {7'd0, data_valid}, 8'd0);
        ctrl_reg = 8'h04; step(2);
        chk("R10 woke", {7'd0, standby}, 8'd0);
        for (int i = 1; i <= 6; i++) begin
            pulse();
            chk("R10 full refill after collision", {7'd0, data_valid}, {7'd0, i == 6});
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule